// File: doc/BRIEF.md
# Peripheral Idle Power-Down Timer

This block decides when an idle serial port may be put to sleep. A loadable 8-bit down-counter is armed whenever the port shows activity. Activity is a host register access, a port interrupt or an external input event. The counter steps down once per tick of a selectable time base, either seconds or minutes. The tick strobes come from a free-running prescaler outside the block. When the count runs out, the block reports the port as sleeping and raises a one-cycle power-down request. Activity on any of the three sources wakes the port again.

A reload value of zero turns the power-down function off. The port then keeps whatever state it holds at that moment. The whole function is gated by two enables, a chip-wide one and a per-port one. All pins are plain control and status levels or strobes. No data stream crosses the boundary, so there is no valid/ready handshake.

Top module: `idle_pd_timer`

## Requirements
- R1: After reset `sleeping` and `pd_req` are 0 and the counter holds 0. Ticks alone, with no activity since reset, never put the port to sleep.
- R2: With both enables at 1 and a nonzero reload value N, an activity strobe on any one of `act_host`, `act_irq` or `act_ext` loads N. After the N-th following tick of the selected base, `sleeping` reads 1 at the output. Before that tick it reads 0.
- R3: `tick_sel_min` = 0 selects `tick_sec`, and `tick_sel_min` = 1 selects `tick_min`. A strobe on the tick that is not selected leaves the counter unchanged.
- R4: Activity while sleeping returns `sleeping` to 0 on the next clock edge. It also reloads the full count, so N further ticks are needed before the next sleep.
- R5: When activity and a selected tick arrive in the same cycle, the activity wins. The counter is reloaded and not decremented.
- R6: While the reload value is 00h and the port is working, ticks never put it to sleep.
- R7: While the reload value is 00h and the port is sleeping, activity does not wake it.
- R8: While either `pm_global_en` or `pm_port_en` is 0, `sleeping` reads 0 from the next edge on and `pd_req` stays 0. The counter holds its value. Once both enables return to 1, the countdown resumes from that value.
- R9: A new reload value written during a countdown does not change the count in progress. It is used at the next reload.
- R10: `pd_req` is 1 for exactly the one cycle in which `sleeping` first reads 1 after working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload_cnt | input | 8 | Idle count loaded on activity; 00h disables power-down |
| tick_sel_min | input | 1 | Time base: 0 = seconds, 1 = minutes |
| pm_global_en | input | 1 | Chip-wide power-management enable |
| pm_port_en | input | 1 | Power-management enable for this port |
| act_host | input | 1 | Host register access strobe |
| act_irq | input | 1 | Port interrupt strobe |
| act_ext | input | 1 | External input event strobe |
| tick_sec | input | 1 | One-cycle strobe each second |
| tick_min | input | 1 | One-cycle strobe each minute |
| sleeping | output | 1 | 1 = port sleeping, 0 = working |
| pd_req | output | 1 | One-cycle power-down request on sleep entry |

## Verification
The bound checker watches the single-cycle rules on every clock. These are the shape of the power-down pulse, forced working while disabled, wake on armed activity, both zero-count freezes, and the fact that sleep is entered only right after an unmasked selected tick. The exact number of ticks to sleep cannot be seen in one cycle, and neither can the count held across a disabled period or the deferred effect of a changed reload value. Only the bench scenarios can show these, by counting ticks against a model of the remaining count.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  typedef enum logic {
    PWR_WORK  = 1'b0,
    PWR_SLEEP = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/pdt_event_sel.sv
// Qualifies the raw strobes: merges activity sources, picks the time base,
// and combines the two enables.
module pdt_event_sel #(
  parameter int N_SRC = 3
) (
  input  logic [N_SRC-1:0] act_vec,
  input  logic             tick_sec,
  input  logic             tick_min,
  input  logic             tick_sel_min,
  input  logic             pm_global_en,
  input  logic             pm_port_en,
  output logic             en,
  output logic             act,
  output logic             tick
);
  assign en   = pm_global_en & pm_port_en;
  assign act  = |act_vec;
  assign tick = tick_sel_min ? tick_min : tick_sec;
endmodule

// File: rtl/pdt_down_counter.sv
// Loadable down-counter; load has priority over decrement.
module pdt_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] load_val,
  output logic             is_zero,
  output logic             is_one
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (dec)    cnt_q <= cnt_q - ONE;
  end

  assign is_zero = (cnt_q == '0);
  assign is_one  = (cnt_q == ONE);
endmodule

// File: rtl/pdt_state_ctl.sv
// Working/sleeping state register and the power-down request pulse.
module pdt_state_ctl
  import pdt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wake,
  input  logic expire,
  output logic sleeping,
  output logic pd_req
);
  pwr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en)         st_d = PWR_WORK;
    else if (wake)   st_d = PWR_WORK;
    else if (expire) st_d = PWR_SLEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= PWR_WORK;
      pd_req <= 1'b0;
    end else begin
      st_q   <= st_d;
      pd_req <= en & ~wake & expire;
    end
  end

  assign sleeping = (st_q == PWR_SLEEP);
endmodule

// File: rtl/idle_pd_timer.sv
module idle_pd_timer
  import pdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload_cnt,
  input  logic             tick_sel_min,
  input  logic             pm_global_en,
  input  logic             pm_port_en,
  input  logic             act_host,
  input  logic             act_irq,
  input  logic             act_ext,
  input  logic             tick_sec,
  input  logic             tick_min,
  output logic             sleeping,
  output logic             pd_req
);
  localparam int N_SRC = 3;

  logic en, act, tick;
  logic frozen, load, dec, wake, expire;
  logic is_zero, is_one;

  pdt_event_sel #(.N_SRC(N_SRC)) u_sel (
    .act_vec      ({act_ext, act_irq, act_host}),
    .tick_sec     (tick_sec),
    .tick_min     (tick_min),
    .tick_sel_min (tick_sel_min),
    .pm_global_en (pm_global_en),
    .pm_port_en   (pm_port_en),
    .en           (en),
    .act          (act),
    .tick         (tick)
  );

  // zero reload value freezes the present state
  assign frozen = (reload_cnt == '0);
  assign load   = en & act;
  assign wake   = load & ~frozen;
  assign dec    = en & tick & ~act & ~frozen & ~sleeping & ~is_zero;
  assign expire = dec & is_one;

  pdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .dec      (dec),
    .load_val (reload_cnt),
    .is_zero  (is_zero),
    .is_one   (is_one)
  );

  pdt_state_ctl u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .wake     (wake),
    .expire   (expire),
    .sleeping (sleeping),
    .pd_req   (pd_req)
  );
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] reload_cnt,
  input logic             tick_sel_min,
  input logic             pm_global_en,
  input logic             pm_port_en,
  input logic             act_host,
  input logic             act_irq,
  input logic             act_ext,
  input logic             tick_sec,
  input logic             tick_min,
  input logic             sleeping,
  input logic             pd_req
);
  logic en_c, act_c, tick_c, zero_c;
  assign en_c   = pm_global_en & pm_port_en;
  assign act_c  = act_host | act_irq | act_ext;
  assign tick_c = tick_sel_min ? tick_min : tick_sec;
  assign zero_c = (reload_cnt == '0);

  a_r10_pd_with_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> sleeping);
  a_r10_pd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |=> !pd_req);
  a_r10_entry_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleeping) |-> pd_req);
  a_r8_disabled_working: assert property (@(posedge clk) disable iff (!rst_n)
    !en_c |=> (!sleeping && !pd_req));
  a_r4_wake_next: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && act_c && !zero_c) |=> !sleeping);
  a_r6_freeze_working: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && zero_c && !sleeping) |=> !sleeping);
  a_r7_freeze_sleeping: assert property (@(posedge clk) disable iff (!rst_n)
    (en_c && zero_c && sleeping) |=> sleeping);
  a_r5_sleep_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleeping && !(en_c && tick_c && !act_c)) |=> !sleeping);
endmodule

bind idle_pd_timer pdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reload_cnt(reload_cnt), .tick_sel_min(tick_sel_min),
  .pm_global_en(pm_global_en), .pm_port_en(pm_port_en), .act_host(act_host),
  .act_irq(act_irq), .act_ext(act_ext), .tick_sec(tick_sec), .tick_min(tick_min),
  .sleeping(sleeping), .pd_req(pd_req)
);

// File: tb/sim_idle_pd_timer.sv
`timescale 1ns/1ps
module sim_idle_pd_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] reload_cnt = 8'd0;
  logic tick_sel_min = 1'b0, pm_global_en = 1'b1, pm_port_en = 1'b1;
  logic act_host = 1'b0, act_irq = 1'b0, act_ext = 1'b0;
  logic tick_sec = 1'b0, tick_min = 1'b0;
  logic sleeping, pd_req;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  idle_pd_timer u0 (.*);

  // one clock; inputs and samples sit 2 ns after the rising edge
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic activity(input int src);
    case (src)
      0: act_host = 1'b1;
      1: act_irq  = 1'b1;
      default: act_ext = 1'b1;
    endcase
    step();
    act_host = 1'b0; act_irq = 1'b0; act_ext = 1'b0;
  endtask

  task automatic tick(input logic minute);
    if (minute) tick_min = 1'b1; else tick_sec = 1'b1;
    step();
    tick_min = 1'b0; tick_sec = 1'b0;
  endtask

  task automatic ticks(input int n, input logic minute);
    for (int i = 0; i < n; i++) begin tick(minute); step(); end
  endtask

  task automatic t_reset();
    chk("R1 reset sleeping", sleeping, 1'b0);
    chk("R1 reset pd_req", pd_req, 1'b0);
    reload_cnt = 8'd3;
    ticks(6, 1'b0);
    chk("R1 no sleep without arming", sleeping, 1'b0);
  endtask

  task automatic t_entry(input int src);
    reload_cnt = 8'd3; tick_sel_min = 1'b0;
    activity(src);
    chk("R2 working after arm", sleeping, 1'b0);
    ticks(2, 1'b0);
    chk("R2 awake before last tick", sleeping, 1'b0);
    tick(1'b0);
    chk("R2 sleep on last tick", sleeping, 1'b1);
    chk("R10 pd_req pulse", pd_req, 1'b1);
    step();
    chk("R10 pd_req drops", pd_req, 1'b0);
    chk("R2 stays asleep", sleeping, 1'b1);
    activity(2);
  endtask

  task automatic t_timebase();
    reload_cnt = 8'd3; tick_sel_min = 1'b1;
    activity(0);
    ticks(5, 1'b0);
    chk("R3 seconds ignored in minute mode", sleeping, 1'b0);
    ticks(2, 1'b1);
    chk("R3 two minutes", sleeping, 1'b0);
    tick(1'b1);
    chk("R3 third minute sleeps", sleeping, 1'b1);
    tick_sel_min = 1'b0;
    activity(0);
  endtask

  task automatic t_wake();
    reload_cnt = 8'd3;
    activity(1); ticks(3, 1'b0);
    chk("R4 asleep before wake", sleeping, 1'b1);
    activity(1);
    chk("R4 wake next cycle", sleeping, 1'b0);
    ticks(2, 1'b0);
    chk("R4 full reload", sleeping, 1'b0);
    tick(1'b0);
    chk("R4 sleeps after full count", sleeping, 1'b1);
    activity(2);
  endtask

  task automatic t_collide();
    reload_cnt = 8'd2;
    activity(0);
    tick(1'b0);
    act_host = 1'b1; tick_sec = 1'b1;
    step();
    act_host = 1'b0; tick_sec = 1'b0;
    tick(1'b0);
    chk("R5 activity beats tick", sleeping, 1'b0);
    tick(1'b0);
    chk("R5 sleeps after reload", sleeping, 1'b1);
    activity(0);
  endtask

  task automatic t_freeze();
    reload_cnt = 8'd0;
    activity(0);
    ticks(8, 1'b0);
    chk("R6 zero count stays working", sleeping, 1'b0);
    reload_cnt = 8'd2;
    activity(0); ticks(2, 1'b0);
    chk("R7 asleep", sleeping, 1'b1);
    reload_cnt = 8'd0;
    activity(2); activity(1); activity(0);
    chk("R7 zero count stays asleep", sleeping, 1'b1);
    reload_cnt = 8'd2;
    activity(0);
    chk("R7 wakes once count nonzero", sleeping, 1'b0);
  endtask

  task automatic t_enable(input logic global);
    reload_cnt = 8'd2;
    activity(0); ticks(2, 1'b0);
    chk("R8 asleep before disable", sleeping, 1'b1);
    if (global) pm_global_en = 1'b0; else pm_port_en = 1'b0;
    step();
    chk("R8 disabled reads working", sleeping, 1'b0);
    chk("R8 no pd_req when disabled", pd_req, 1'b0);
    pm_global_en = 1'b1; pm_port_en = 1'b1;
    reload_cnt = 8'd3;
    activity(1); tick(1'b0);
    if (global) pm_global_en = 1'b0; else pm_port_en = 1'b0;
    ticks(5, 1'b0);
    chk("R8 no sleep while disabled", sleeping, 1'b0);
    pm_global_en = 1'b1; pm_port_en = 1'b1;
    tick(1'b0);
    chk("R8 count held, one left", sleeping, 1'b0);
    tick(1'b0);
    chk("R8 resumes from held count", sleeping, 1'b1);
    activity(0);
  endtask

  task automatic t_newcount();
    reload_cnt = 8'd4;
    activity(0);
    reload_cnt = 8'd1;
    ticks(3, 1'b0);
    chk("R9 new count not applied mid-run", sleeping, 1'b0);
    tick(1'b0);
    chk("R9 old count completes", sleeping, 1'b1);
    activity(1);
    tick(1'b0);
    chk("R9 new count used at reload", sleeping, 1'b1);
    activity(0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    t_reset();
    for (int s = 0; s < 3; s++) t_entry(s);
    t_timebase();
    t_wake();
    t_collide();
    t_freeze();
    t_enable(1'b1);
    t_enable(1'b0);
    t_newcount();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule